// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block gathers the interrupt conditions of a FIFO-equipped UART, masks each one with its enable, and ranks them on six priority levels. It drives one interrupt request line and an 8-bit status word that reports only the most urgent enabled source. The serial shifter, the FIFOs, the flow-control character matcher and the host bus decoder sit around it. They supply set pulses, levels and service strobes.

Edge-type sources are held in sticky flags, and each flag has its own clear event. The two receive sources are levels that come from the FIFO logic. The status word is captured only when the status register is read, and it holds that value until the next read. A lower-ranked source therefore shows up only after the higher one has been serviced and the status is read again. The flow-control sources (Xoff or special-character match, and CTS/RTS change) take part only while the enhanced-feature enable is set. The Xoff flag stays set until an Xon arrives.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `isr_o` is 0x01 and `irq_o` is 0.
- R2: `isr_o[5:0]` codes: line-status error 000110, receive data ready 000100, receive timeout 001100, transmit holding empty 000010, modem status 000000, Xoff/special character 010000, CTS/RTS change 100000.
- R3: Priority from highest to lowest is line status, receive data ready, receive timeout, transmit holding empty, modem status, Xoff, CTS/RTS. When data ready and timeout are both pending, data ready is reported.
- R4: `isr_o[7:6]` reads 11 when `fifo_en_i` is 1 at the read, and 00 when it is 0.
- R5: When `enh_en_i` is 0, the Xoff and CTS/RTS sources are neither reported nor raise `irq_o`, so `isr_o[5:4]` reads 00.
- R6: `irq_o` is 1 exactly when an enabled source is pending. A read with nothing pending returns code 000001.
- R7: `src_en_i` masks the sources per bit: bit 0 line status, bit 1 both receive sources, bit 2 transmit holding empty, bit 3 modem status, bit 4 Xoff, bit 5 CTS/RTS.
- R8: `isr_o` is loaded only in the cycle after `isr_rd_i`, and it holds its value until the next read.
- R9: The transmit-holding-empty flag is cleared by `thr_wr_i` or by a status read that reported it.
- R10: `lsr_rd_i` clears the line-status flag and `msr_rd_i` clears the modem-status flag. Neither strobe affects any other flag.
- R11: The Xoff flag is cleared only by `xon_det_i`. The CTS/RTS flag is cleared by a status read that reported it.
- R12: When a set pulse and a clear event for the same flag fall in one cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enh_en_i | input | 1 | Enhanced-feature enable for the two flow-control sources |
| fifo_en_i | input | 1 | FIFO mode flag, reported in status bits 7:6 |
| src_en_i | input | 6 | Per-source enables (see R7) |
| lsr_err_i | input | 1 | Line-status error set pulse |
| rx_ready_i | input | 1 | Receive data available (level) |
| rx_tmo_i | input | 1 | Receive timeout (level) |
| thr_empty_i | input | 1 | Transmit holding empty set pulse |
| msr_chg_i | input | 1 | Modem status change set pulse |
| xoff_det_i | input | 1 | Xoff/special character match set pulse |
| xon_det_i | input | 1 | Xon received, clears the Xoff flag |
| flow_chg_i | input | 1 | CTS/RTS change set pulse |
| isr_rd_i | input | 1 | Status register read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| isr_o | output | 8 | Captured status word |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can fall in one cycle: a set pulse for a flag and the service event that clears it. Examples are a transmit-empty pulse with a holding-register write, and an Xoff match with an Xon. The bench drives both inputs on the same edge. It then judges the request line and a following status read, and both must still show the source. A second case is a clear-on-read that lands while a lower source is pending. Here the bench reads twice and expects the lower code to appear only on the second read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 7;
  localparam int NFLAG  = 5;
  localparam int NEN    = 6;
  localparam int CODE_W = 6;
  localparam int ISR_W  = 8;
  localparam int IDX_W  = $clog2(NSRC);

  // index order is priority order, 0 = highest
  typedef enum logic [IDX_W-1:0] {
    SRC_LSR  = 3'd0,
    SRC_RXD  = 3'd1,
    SRC_RXTO = 3'd2,
    SRC_THR  = 3'd3,
    SRC_MSR  = 3'd4,
    SRC_XOFF = 3'd5,
    SRC_FLOW = 3'd6
  } src_e;

  // flag slots for the sticky sources
  localparam int FL_LSR  = 0;
  localparam int FL_THR  = 1;
  localparam int FL_MSR  = 2;
  localparam int FL_XOFF = 3;
  localparam int FL_FLOW = 4;

  localparam logic [CODE_W-1:0] CODE_IDLE = 6'b000001;

  function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx);
    case (idx)
      SRC_LSR:  return 6'b000110;
      SRC_RXD:  return 6'b000100;
      SRC_RXTO: return 6'b001100;
      SRC_THR:  return 6'b000010;
      SRC_MSR:  return 6'b000000;
      SRC_XOFF: return 6'b010000;
      SRC_FLOW: return 6'b100000;
      default:  return CODE_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[g] <= 1'b0;
      else if (set_i[g])  q_o[g] <= 1'b1;   // set dominates clear
      else if (clr_i[g])  q_o[g] <= 1'b0;
    end

    assert_set_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> q_o[g]);
    assert_flag_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !q_o[g]);
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N   = NSRC,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o   = |req_i;
  assign grant_o = any_o ? (N'(1) << idx_o) : '0;

  assert_onehot_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  assert_grant_in_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enh_en_i,
  input  logic             fifo_en_i,
  input  logic [NEN-1:0]   src_en_i,
  input  logic             lsr_err_i,
  input  logic             rx_ready_i,
  input  logic             rx_tmo_i,
  input  logic             thr_empty_i,
  input  logic             msr_chg_i,
  input  logic             xoff_det_i,
  input  logic             xon_det_i,
  input  logic             flow_chg_i,
  input  logic             isr_rd_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             thr_wr_i,
  output logic [ISR_W-1:0] isr_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  logic [NSRC-1:0]  pend, src_msk, req, grant;
  logic [IDX_W-1:0] win_idx;
  logic             any_req;
  logic [ISR_W-1:0] isr_q;

  assign flag_set = {flow_chg_i, xoff_det_i, msr_chg_i, thr_empty_i, lsr_err_i};

  always_comb begin
    flag_clr          = '0;
    flag_clr[FL_LSR]  = lsr_rd_i;
    flag_clr[FL_THR]  = thr_wr_i | (isr_rd_i & grant[SRC_THR]);
    flag_clr[FL_MSR]  = msr_rd_i;
    flag_clr[FL_XOFF] = xon_det_i;
    flag_clr[FL_FLOW] = isr_rd_i & grant[SRC_FLOW];
  end

  uart_irq_flags #(.WIDTH(NFLAG)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .q_o    (flag_q)
  );

  always_comb begin
    pend           = '0;
    pend[SRC_LSR]  = flag_q[FL_LSR];
    pend[SRC_RXD]  = rx_ready_i;
    pend[SRC_RXTO] = rx_tmo_i;
    pend[SRC_THR]  = flag_q[FL_THR];
    pend[SRC_MSR]  = flag_q[FL_MSR];
    pend[SRC_XOFF] = flag_q[FL_XOFF];
    pend[SRC_FLOW] = flag_q[FL_FLOW];

    src_msk           = '0;
    src_msk[SRC_LSR]  = src_en_i[0];
    src_msk[SRC_RXD]  = src_en_i[1];
    src_msk[SRC_RXTO] = src_en_i[1];
    src_msk[SRC_THR]  = src_en_i[2];
    src_msk[SRC_MSR]  = src_en_i[3];
    src_msk[SRC_XOFF] = src_en_i[4] & enh_en_i;
    src_msk[SRC_FLOW] = src_en_i[5] & enh_en_i;
  end

  assign req = pend & src_msk;

  uart_irq_prio #(.N(NSRC)) i_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (any_req)
  );

  // snapshot on read, held for the access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       isr_q <= {2'b00, CODE_IDLE};
    else if (isr_rd_i) isr_q <= {{2{fifo_en_i}}, any_req ? src_code(win_idx) : CODE_IDLE};
  end

  assign isr_o = isr_q;
  assign irq_o = any_req;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isr_rd_i |=> $stable(isr_o));
  assert_fifo_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_rd_i |=> (isr_o[7:6] == {2{$past(fifo_en_i)}}));
  assert_enh_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_rd_i && !enh_en_i) |=> (isr_o[5:4] == 2'b00));
  assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_rd_i && !irq_o) |=> (isr_o[5:0] == CODE_IDLE));
  assert_xoff_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[FL_XOFF] && !xon_det_i) |=> flag_q[FL_XOFF]);
endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enh_en = 1'b1, fifo_en = 1'b1;
  logic [5:0] src_en = 6'h3f;
  logic       lsr_err = 0, rx_ready = 0, rx_tmo = 0, thr_empty = 0, msr_chg = 0;
  logic       xoff_det = 0, xon_det = 0, flow_chg = 0;
  logic       isr_rd = 0, lsr_rd = 0, msr_rd = 0, thr_wr = 0;
  logic [7:0] isr;
  logic       irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_irq_ident i_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_n), .enh_en_i(enh_en), .fifo_en_i(fifo_en),
    .src_en_i(src_en), .lsr_err_i(lsr_err), .rx_ready_i(rx_ready), .rx_tmo_i(rx_tmo),
    .thr_empty_i(thr_empty), .msr_chg_i(msr_chg), .xoff_det_i(xoff_det),
    .xon_det_i(xon_det), .flow_chg_i(flow_chg), .isr_rd_i(isr_rd),
    .lsr_rd_i(lsr_rd), .msr_rd_i(msr_rd), .thr_wr_i(thr_wr),
    .isr_o(isr), .irq_o(irq)
  );

  // sets: [0] lsr [1] thr [2] msr [3] xoff [4] flow
  typedef struct packed {
    logic [4:0] sets;
    logic       rx;
    logic       tmo;
    logic [5:0] en;
    logic       enh;
    logic       fifo;
    logic [7:0] isr;
    logic       irq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{5'b00001, 1'b0, 1'b0, 6'h3f, 1'b1, 1'b1, 8'hc6, 1'b1},  // R2 lsr
    '{5'b00000, 1'b1, 1'b0, 6'h3f, 1'b1, 1'b1, 8'hc4, 1'b1},  // R2 rxd
    '{5'b00000, 1'b0, 1'b1, 6'h3f, 1'b1, 1'b1, 8'hcc, 1'b1},  // R2 timeout
    '{5'b00000, 1'b1, 1'b1, 6'h3f, 1'b1, 1'b1, 8'hc4, 1'b1},  // R3 rxd over timeout
    '{5'b00010, 1'b0, 1'b0, 6'h3f, 1'b1, 1'b0, 8'h02, 1'b1},  // R2/R4 thr, non-FIFO
    '{5'b00100, 1'b0, 1'b0, 6'h3f, 1'b1, 1'b1, 8'hc0, 1'b1},  // R2 msr
    '{5'b01000, 1'b0, 1'b0, 6'h3f, 1'b1, 1'b1, 8'hd0, 1'b1},  // R2 xoff
    '{5'b10000, 1'b0, 1'b0, 6'h3f, 1'b1, 1'b1, 8'he0, 1'b1},  // R2 flow
    '{5'b11000, 1'b0, 1'b0, 6'h3f, 1'b0, 1'b1, 8'hc1, 1'b0},  // R5 gated
    '{5'b11111, 1'b1, 1'b1, 6'h3f, 1'b1, 1'b1, 8'hc6, 1'b1},  // R3 all
    '{5'b00001, 1'b1, 1'b0, 6'h3e, 1'b1, 1'b1, 8'hc4, 1'b1},  // R7 lsr masked
    '{5'b00110, 1'b0, 1'b0, 6'h3f, 1'b1, 1'b1, 8'hc2, 1'b1},  // R3 thr over msr
    '{5'b00000, 1'b0, 1'b0, 6'h3f, 1'b1, 1'b1, 8'hc1, 1'b0},  // R6 idle
    '{5'b10100, 1'b0, 1'b0, 6'h3f, 1'b1, 1'b1, 8'hc0, 1'b1},  // R3 msr over flow
    '{5'b11111, 1'b1, 1'b1, 6'h00, 1'b1, 1'b0, 8'h01, 1'b0},  // R7 all masked
    '{5'b11010, 1'b0, 1'b0, 6'h3b, 1'b1, 1'b1, 8'hd0, 1'b1}   // R7 thr masked
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {lsr_err, rx_ready, rx_tmo, thr_empty, msr_chg, xoff_det, xon_det, flow_chg} = '0;
    {isr_rd, lsr_rd, msr_rd, thr_wr} = '0;
    enh_en = 1'b1; fifo_en = 1'b1; src_en = 6'h3f;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic pulse_sets(input logic [4:0] s);
    {flow_chg, xoff_det, msr_chg, thr_empty, lsr_err} = s;
    step();
    {flow_chg, xoff_det, msr_chg, thr_empty, lsr_err} = '0;
  endtask

  task automatic do_rd();
    isr_rd = 1'b1;
    step();
    isr_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step();
    rst_n = 1'b1;
    step();
    chk("R1 isr", isr, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      rx_ready = VECS[v].rx; rx_tmo = VECS[v].tmo; src_en = VECS[v].en;
      enh_en = VECS[v].enh; fifo_en = VECS[v].fifo;
      pulse_sets(VECS[v].sets);
      chk($sformatf("R6 vec%0d irq", v), {7'b0, irq}, {7'b0, VECS[v].irq});
      do_rd();
      chk($sformatf("R2 vec%0d isr", v), isr, VECS[v].isr);
    end

    // R8 hold between reads, then R10 servicing order
    do_reset();
    pulse_sets(5'b00001);
    do_rd();
    chk("R8 first read", isr, 8'hc6);
    rx_ready = 1'b1;
    pulse_sets(5'b00100);
    step(); step();
    chk("R8 held", isr, 8'hc6);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    do_rd();
    chk("R10 after lsr read", isr, 8'hc4);
    rx_ready = 1'b0;
    do_rd();
    chk("R10 msr visible", isr, 8'hc0);
    msr_rd = 1'b1; step(); msr_rd = 1'b0;
    chk("R10 msr cleared irq", {7'b0, irq}, 8'h00);
    do_rd();
    chk("R10 idle", isr, 8'hc1);

    // R9 transmit-empty clears
    do_reset();
    pulse_sets(5'b00010);
    do_rd();
    chk("R9 thr reported", isr, 8'hc2);
    chk("R9 cleared by read", {7'b0, irq}, 8'h00);
    pulse_sets(5'b00010);
    chk("R9 thr pending", {7'b0, irq}, 8'h01);
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    chk("R9 cleared by write", {7'b0, irq}, 8'h00);

    // R3 lower source after service and reread
    do_reset();
    pulse_sets(5'b00011);
    do_rd();
    chk("R3 lsr first", isr, 8'hc6);
    do_rd();
    chk("R3 still lsr", isr, 8'hc6);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    do_rd();
    chk("R3 thr next", isr, 8'hc2);

    // R11 Xoff sticky, CTS/RTS cleared by read
    do_reset();
    pulse_sets(5'b01000);
    do_rd();
    chk("R11 xoff", isr, 8'hd0);
    {lsr_rd, msr_rd, thr_wr} = 3'b111; step(); {lsr_rd, msr_rd, thr_wr} = 3'b000;
    do_rd();
    chk("R11 xoff sticky", isr, 8'hd0);
    xon_det = 1'b1; step(); xon_det = 1'b0;
    chk("R11 xon clears", {7'b0, irq}, 8'h00);
    pulse_sets(5'b10000);
    do_rd();
    chk("R11 flow", isr, 8'he0);
    do_rd();
    chk("R11 flow cleared", isr, 8'hc1);

    // R12 set and clear in one cycle
    do_reset();
    thr_empty = 1'b1; thr_wr = 1'b1; step(); thr_empty = 1'b0; thr_wr = 1'b0;
    chk("R12 thr set wins", {7'b0, irq}, 8'h01);
    do_rd();
    chk("R12 thr read", isr, 8'hc2);
    pulse_sets(5'b01000);
    xoff_det = 1'b1; xon_det = 1'b1; step(); xoff_det = 1'b0; xon_det = 1'b0;
    chk("R12 xoff set wins", {7'b0, irq}, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule